// File: doc/BRIEF.md
# Peripheral Configuration Write Sequencer

This block carries out one byte-wide configuration write to one of several downstream programmable devices that load in a peripheral asynchronous mode. Each device has three lines: a low-active write strobe driven by this block, a low-active BUSY status and a DONE status. A bus-side handshake starts each write with a low-active request. The request is registered, and the block captures the write at the falling edge it detects. It then checks the chosen device's status, pulses that device's strobe for a fixed number of clocks, and waits for the device to show a complete BUSY cycle before it raises the acknowledge.

The device is chosen by a four-bit field taken from address bits 5:2. If the status before the write is wrong, the strobe is skipped. The write is still acknowledged, and sticky flags record the cause. If a device never answers with BUSY, the sequencer waits until it is reset. It does not time out on its own. Reads in the configuration window, requests outside the window and unused selector codes are never acknowledged.

Top module: `cfg_write_seq`

## Requirements
- R1: After reset the acknowledge is low, every strobe output is high and all three error flags are low.
- R2: A write is accepted only if, at the detected falling edge of `req_n`, `win_sel` is 1, `wr_n` is 0 and `addr_sel` is below the device count. A read, a request outside the window, or a selector of 10 to 15 produces no strobe and no acknowledge.
- R3: Selector value n drives the strobe of device n and no other. Values 0 to 7 are pipe units, 8 is the track unit and 9 is the opcode unit. At most one strobe is low at any time.
- R4: Before the strobe, the selected device must show `busy_n` high and `done` low. If it does not, there is no strobe, the acknowledge is raised, `err_cfg` is set, `err_busy` is set when `busy_n` was low, and `err_done` is set when `done` was high.
- R5: On a good status the strobe of the selected device stays low for exactly ceil(STRB_MIN_NS / CLK_PERIOD_NS) clocks, which is 5 clocks at the defaults.
- R6: After a strobe, the acknowledge rises only once the selected device's `busy_n` has been seen low and then high again.
- R7: The acknowledge stays high while `req_n` stays low. It is still high one clock after `req_n` rises and low two clocks after, when the block is idle again.
- R8: If `busy_n` never completes its high-low-high cycle, the block raises no acknowledge until reset.
- R9: The error flags keep their value until the next accepted write, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Transfer request from the bus handshake, active low |
| wr_n | input | 1 | Direction: 0 is write, 1 is read |
| win_sel | input | 1 | Address lies in the configuration window |
| addr_sel | input | SEL_W | Device selector (address bits 5:2) |
| busy_n | input | NUM_TGT | Per-device BUSY, low while busy |
| done | input | NUM_TGT | Per-device DONE status |
| wrs_n | output | NUM_TGT | Per-device write strobe, active low |
| ack | output | 1 | Transfer acknowledge to the bus handshake |
| err_cfg | output | 1 | A write was refused because of bad status |
| err_busy | output | 1 | The refused write saw BUSY low |
| err_done | output | 1 | The refused write saw DONE high |

## Verification
The bench builds the block with its defaults: ten devices, a four-bit selector, a 20 ns clock and a 100 ns minimum strobe, which gives a five-clock strobe, with the strobe gated by the registered BUSY. Because the selector is four bits wide and only ten devices exist, codes 10 to 15 can be driven and must be refused. The short strobe count lets many random writes run in the cycle budget. These writes use random device delays of 1 to 4 clocks and BUSY low times of 2 to 20 clocks. Two hang cases, one where BUSY never falls and one where it never rises, are each ended by a reset.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
package cfg_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_STRB  = 3'd2,
      ST_WAIT  = 3'd3,
      ST_ACK   = 3'd4
   } seq_st_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/cfg_req_capture.sv
`timescale 1ns/1ps
module cfg_req_capture #(
   parameter int SEL_W   = 4,
   parameter int NUM_TGT = 10,
   parameter int TGT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_n,
   input  logic             wr_n,
   input  logic             win_sel,
   input  logic [SEL_W-1:0] code,
   input  logic             clr,
   output logic             pend,
   output logic [TGT_W-1:0] tgt,
   output logic             req_idle
);

   logic req_s, req_d;
   logic fall, code_ok, accept;

   if (TGT_W > SEL_W) begin : g_bad_w
      $error("selector narrower than target index");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_s <= 1'b1;
         req_d <= 1'b1;
      end else begin
         req_s <= req_n;
         req_d <= req_s;
      end
   end

   assign fall     = req_d & ~req_s;
   assign code_ok  = int'(code) < NUM_TGT;
   assign accept   = fall & win_sel & ~wr_n & code_ok;
   assign req_idle = req_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         tgt  <= '0;
      end else if (clr) begin
         pend <= 1'b0;
      end else if (accept) begin
         pend <= 1'b1;
         tgt  <= code[TGT_W-1:0];
      end
   end

   // R2
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);

   // R2
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fall) |=> !pend);

endmodule

// File: rtl/cfg_busy_track.sv
`timescale 1ns/1ps
module cfg_busy_track (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic bsy_hi,
   output logic seq_done
);

   logic seen_low, seen_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_low  <= 1'b0;
         seen_high <= 1'b0;
      end else if (clr) begin
         seen_low  <= 1'b0;
         seen_high <= 1'b0;
      end else if (en) begin
         if (!bsy_hi)
            seen_low <= 1'b1;
         if (seen_low && bsy_hi)
            seen_high <= 1'b1;
      end
   end

   assign seq_done = seen_high;

   // R6
   busy_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> seen_low);

   // R6
   busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !seq_done);

endmodule

// File: rtl/cfg_seq_fsm.sv
`timescale 1ns/1ps
module cfg_seq_fsm
   import cfg_seq_pkg::*;
#(
   parameter int STRB_CLKS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic bsy_hi,
   input  logic done_sel,
   input  logic seq_done,
   input  logic req_idle,
   output logic strb_on,
   output logic ack,
   output logic det_clr,
   output logic det_en,
   output logic cap_clr,
   output logic err_cfg,
   output logic err_busy,
   output logic err_done
);

   localparam int CNT_W = $clog2(STRB_CLKS + 1);

   if (STRB_CLKS < 1) begin : g_bad_cnt
      $error("strobe length must be at least one clock");
   end

   seq_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic             status_ok;

   assign status_ok = bsy_hi & ~done_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         err_cfg  <= 1'b0;
         err_busy <= 1'b0;
         err_done <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (pend) begin
               st       <= ST_CHECK;
               err_cfg  <= 1'b0;
               err_busy <= 1'b0;
               err_done <= 1'b0;
            end
            ST_CHECK: if (status_ok) begin
               st  <= ST_STRB;
               cnt <= '0;
            end else begin
               st       <= ST_ACK;
               err_cfg  <= 1'b1;
               err_busy <= ~bsy_hi;
               err_done <= done_sel;
            end
            ST_STRB: if (cnt == CNT_W'(STRB_CLKS - 1))
               st <= ST_WAIT;
            else
               cnt <= cnt + 1'b1;
            ST_WAIT: if (seq_done)
               st <= ST_ACK;
            ST_ACK: if (req_idle)
               st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign strb_on = (st == ST_STRB);
   assign ack     = (st == ST_ACK);
   assign det_clr = (st == ST_IDLE);
   assign det_en  = (st == ST_STRB) || (st == ST_WAIT);
   assign cap_clr = (st == ST_ACK);

   // R4
   bad_status_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CHECK && !status_ok) |=> (ack && err_cfg && !strb_on));

   // R5
   strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_on) |-> ($past(cnt) == CNT_W'(STRB_CLKS - 1)));

   // R7
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req_idle) |=> ack);

   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !seq_done) |=> (st == ST_WAIT));

endmodule

// File: rtl/cfg_write_seq.sv
`timescale 1ns/1ps
module cfg_write_seq
   import cfg_seq_pkg::*;
#(
   parameter int NUM_TGT       = 10,
   parameter int SEL_W         = 4,
   parameter int CLK_PERIOD_NS = 20,
   parameter int STRB_MIN_NS   = 100,
   parameter bit GATE_ON_BUSY  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_n,
   input  logic               wr_n,
   input  logic               win_sel,
   input  logic [SEL_W-1:0]   addr_sel,
   input  logic [NUM_TGT-1:0] busy_n,
   input  logic [NUM_TGT-1:0] done,
   output logic [NUM_TGT-1:0] wrs_n,
   output logic               ack,
   output logic               err_cfg,
   output logic               err_busy,
   output logic               err_done
);

   localparam int TGT_W     = $clog2(NUM_TGT);
   localparam int STRB_CLKS = ceil_div(STRB_MIN_NS, CLK_PERIOD_NS);

   if (NUM_TGT < 2 || NUM_TGT > (1 << SEL_W)) begin : g_bad_tgt
      $error("device count does not fit the selector");
   end
   if (CLK_PERIOD_NS < 1 || STRB_CLKS * CLK_PERIOD_NS < STRB_MIN_NS) begin : g_bad_clk
      $error("strobe clock count misses the minimum width");
   end

   logic [NUM_TGT-1:0] busy_q, done_q;
   logic [TGT_W-1:0]   tgt;
   logic pend, req_idle, cap_clr;
   logic bsy_sel, done_sel, seq_done, det_clr, det_en, strb_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '1;
         done_q <= '0;
      end else begin
         busy_q <= busy_n;
         done_q <= done;
      end
   end

   assign bsy_sel  = busy_q[tgt];
   assign done_sel = done_q[tgt];

   cfg_req_capture #(
      .SEL_W   (SEL_W),
      .NUM_TGT (NUM_TGT),
      .TGT_W   (TGT_W)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_n    (req_n),
      .wr_n     (wr_n),
      .win_sel  (win_sel),
      .code     (addr_sel),
      .clr      (cap_clr),
      .pend     (pend),
      .tgt      (tgt),
      .req_idle (req_idle)
   );

   cfg_busy_track u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (det_clr),
      .en       (det_en),
      .bsy_hi   (bsy_sel),
      .seq_done (seq_done)
   );

   cfg_seq_fsm #(
      .STRB_CLKS (STRB_CLKS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend),
      .bsy_hi   (bsy_sel),
      .done_sel (done_sel),
      .seq_done (seq_done),
      .req_idle (req_idle),
      .strb_on  (strb_on),
      .ack      (ack),
      .det_clr  (det_clr),
      .det_en   (det_en),
      .cap_clr  (cap_clr),
      .err_cfg  (err_cfg),
      .err_busy (err_busy),
      .err_done (err_done)
   );

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_strb
      logic hit;
      assign hit = strb_on && (tgt == TGT_W'(i));
      if (GATE_ON_BUSY) begin : g_gate
         assign wrs_n[i] = ~(hit & busy_q[i]);
      end else begin : g_raw
         assign wrs_n[i] = ~hit;
      end
   end

   // R3
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~wrs_n) <= 1);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !ack && !strb_on) |-> (wrs_n == '1));

endmodule

// File: tb/test_cfg_write_seq.sv
`timescale 1ns/1ps
module test_cfg_write_seq;

   localparam int NT     = 10;
   localparam int STRB   = 5;
   localparam int LIMIT  = 120;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          win_sel = 1'b0;
   logic [3:0]    addr_sel = '0;
   logic [NT-1:0] busy_n = '1;
   logic [NT-1:0] done = '0;
   logic [NT-1:0] wrs_n;
   logic          ack, err_cfg, err_busy, err_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cfg_write_seq i_cfg_write_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_n    (req_n),
      .wr_n     (wr_n),
      .win_sel  (win_sel),
      .addr_sel (addr_sel),
      .busy_n   (busy_n),
      .done     (done),
      .wrs_n    (wrs_n),
      .ack      (ack),
      .err_cfg  (err_cfg),
      .err_busy (err_busy),
      .err_done (err_done)
   );

   function automatic bit exp_valid(input int code, input bit wr, input bit insel);
      return insel && wr && code >= 0 && code < NT;
   endfunction

   function automatic bit exp_bad(input bit pre_bsy, input bit pre_dn);
      return pre_bsy || pre_dn;
   endfunction

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // mode 0: normal device, 1: BUSY never falls, 2: BUSY never rises
   task automatic xact(input int code, input bit wr, input bit insel,
                       input bit pre_bsy, input bit pre_dn,
                       input int dly, input int blen, input int mode);
      bit valid, bad, got_ack, busy_back, strb_seen, prev_low, cur_low;
      int strb_cnt, other_cnt, phase, tmr, lim;
      valid = exp_valid(code, wr, insel);
      bad   = exp_bad(pre_bsy, pre_dn);
      busy_n = '1;
      done   = '0;
      if (code >= 0 && code < NT) begin
         busy_n[code] = ~pre_bsy;
         done[code]   = pre_dn;
      end
      addr_sel = 4'(code);
      wr_n     = ~wr;
      win_sel  = insel;
      req_n    = 1'b0;
      got_ack = 0; busy_back = 0; strb_seen = 0; prev_low = 0;
      strb_cnt = 0; other_cnt = 0; phase = 0; tmr = 0;
      lim = valid ? LIMIT : 40;
      for (int c = 0; c < lim; c++) begin
         @(negedge clk);
         cur_low = (code >= 0 && code < NT) ? ~wrs_n[code] : 1'b0;
         if (cur_low) strb_cnt++;
         for (int k = 0; k < NT; k++)
            if (k != code && !wrs_n[k]) other_cnt++;
         if (prev_low && !cur_low) begin strb_seen = 1; phase = 1; tmr = dly; end
         prev_low = cur_low;
         if (phase == 1) begin
            tmr--;
            if (tmr <= 0) begin
               if (mode != 1) begin busy_n[code] = 1'b0; phase = 2; tmr = blen; end
               else phase = 9;
            end
         end else if (phase == 2) begin
            tmr--;
            if (tmr <= 0) begin
               if (mode != 2) begin busy_n[code] = 1'b1; busy_back = 1; end
               phase = 9;
            end
         end
         if (ack) begin got_ack = 1; break; end
      end
      if (!valid) begin
         chk("R2 no ack on refused request", int'(got_ack), 0);
         chk("R2 no strobe on refused request", strb_cnt + other_cnt, 0);
      end else if (bad) begin
         chk("R4 ack after bad status", int'(got_ack), 1);
         chk("R4 no strobe after bad status", strb_cnt + other_cnt, 0);
         chk("R4 err_cfg", int'(err_cfg), 1);
         chk("R4 err_busy", int'(err_busy), int'(pre_bsy));
         chk("R4 err_done", int'(err_done), int'(pre_dn));
      end else if (mode != 0) begin
         chk("R8 no ack without BUSY cycle", int'(got_ack), 0);
         chk("R5 strobe width", strb_cnt, STRB);
      end else begin
         chk("R6 ack after BUSY cycle", int'(got_ack), 1);
         chk("R6 ack only after BUSY high again", int'(busy_back), 1);
         chk("R5 strobe width", strb_cnt, STRB);
         chk("R3 only selected strobe", other_cnt, 0);
         chk("R9 flags cleared by accepted write", int'({err_cfg, err_busy, err_done}), 0);
      end
      if (got_ack) begin
         repeat (3) @(negedge clk);
         chk("R7 ack held while request low", int'(ack), 1);
         req_n = 1'b1;
         @(negedge clk);
         chk("R7 ack one clock after release", int'(ack), 1);
         @(negedge clk);
         chk("R7 ack dropped after release", int'(ack), 0);
      end else if (valid && mode != 0) begin
         repeat (20) @(negedge clk);
         chk("R8 still waiting", int'(ack), 0);
         req_n = 1'b1;
         do_reset();
         chk("R1 ack low after reset", int'(ack), 0);
         chk("R1 strobes high after reset", int'(wrs_n), (1 << NT) - 1);
         chk("R1 flags low after reset", int'({err_cfg, err_busy, err_done}), 0);
      end else begin
         req_n = 1'b1;
      end
      busy_n = '1;
      done   = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1F2E3D4C);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ack low after reset", int'(ack), 0);
      chk("R1 strobes high after reset", int'(wrs_n), (1 << NT) - 1);
      chk("R1 flags low after reset", int'({err_cfg, err_busy, err_done}), 0);

      // R3: every selector value reaches its own device
      for (int t = 0; t < NT; t++) xact(t, 1, 1, 0, 0, 2, 4, 0);
      // R2: read, outside window, unused codes
      xact(3, 0, 1, 0, 0, 1, 3, 0);
      xact(3, 1, 0, 0, 0, 1, 3, 0);
      for (int t = NT; t < 16; t++) xact(t, 1, 1, 0, 0, 1, 3, 0);
      // R4 then R9
      xact(5, 1, 1, 1, 0, 1, 3, 0);
      xact(6, 1, 1, 0, 1, 1, 3, 0);
      xact(7, 1, 1, 1, 1, 1, 3, 0);
      xact(2, 0, 1, 0, 0, 1, 3, 0);
      chk("R9 flags kept over refused request", int'(err_cfg), 1);
      xact(2, 1, 1, 0, 0, 1, 2, 0);
      // R6 corner: shortest and longest BUSY
      xact(0, 1, 1, 0, 0, 1, 2, 0);
      xact(9, 1, 1, 0, 0, 4, 20, 0);
      // R8: device never falls busy, then never returns
      xact(4, 1, 1, 0, 0, 2, 5, 1);
      xact(8, 1, 1, 0, 0, 2, 5, 2);
      xact(1, 1, 1, 0, 0, 2, 5, 0);

      for (int n = 0; n < 60; n++) begin
         int code, dly, blen;
         bit wr, insel, pb, pd;
         code  = $urandom_range(0, 11);
         wr    = ($urandom % 8) != 0;
         insel = ($urandom % 8) != 0;
         pb    = ($urandom % 6) == 0;
         pd    = ($urandom % 6) == 0;
         dly   = $urandom_range(1, 4);
         blen  = $urandom_range(2, 20);
         xact(code, wr, insel, pb, pd, dly, blen, 0);
      end
      finish_run();
   end

endmodule